// File: doc/BRIEF.md
# Bit-Aligned Receive Byte Packer with First-Collision Tracking

This block sits behind a receive line decoder. It takes a stream of decoded data bits, one per strobe, and packs them into bytes that are written to a receive FIFO. The first bit of a frame goes to a programmable bit position inside the first byte, so a frame can start partway through a byte. A zero offset gives plain byte-oriented reception. At end of frame, any partly filled byte is written out and a 3-bit field reports how far the final byte was filled.

The decoder can flag a bit as a collision. The packer records the absolute position of the first flagged bit, with the starting offset included, and marks that position valid when it lies inside the first 64 bit positions. A control input selects whether bits after the first collision are stored as received or forced to zero. Forcing them to zero is what tree-walking anticollision needs.

Top module: `rx_bit_packer`

## Requirements
- R1: At start of frame the first stored bit lands at bit position `alignCfg` of the first byte. Each later bit goes one position higher, and after bit 7 the next bit lands at bit 0 of the following byte. For example, with `alignCfg`=7 the second bit becomes bit 0 of the second byte.
- R2: When a bit strobe fills bit 7, the completed byte appears on `byteWrData` with `byteWrValid` high for exactly one cycle, starting on the clock edge after that strobe.
- R3: On end of frame, a byte holding stored bits that was not yet written is written one cycle later. Its positions that received no bit read 0. If no bits are pending, nothing is written.
- R4: On end of frame `lastBits` is loaded with (`alignCfg` + bits received) mod 8, where 0 means the whole final byte is valid. It reads 0 from start of frame until that end of frame.
- R5: With `keepAfterColl`=0, every bit after the first collision bit is stored as 0, while the collision bit itself is stored as received. With `keepAfterColl`=1, all bits are stored as received.
- R6: On the first collision, `collPos` is set to `alignCfg` plus the zero-based index of the collided bit. `collPosValid` is set only if that sum is below 64.
- R7: Collisions after the first one in a frame change neither `collPos` nor `collPosValid`.
- R8: A start-of-frame strobe clears `collPos`, `collPosValid`, `lastBits` and any partial byte. It also reloads the bit position from `alignCfg`.
- R9: Bit and collision strobes outside a frame, a bit strobe in the same cycle as end of frame, and a collision strobe without a bit strobe are all ignored. None of them writes a byte or changes `lastBits` or the collision outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alignCfg | input | 3 | Bit position of the first stored bit, sampled at start of frame |
| keepAfterColl | input | 1 | 1: keep bits after a collision; 0: store them as 0 |
| sofStrobe | input | 1 | Start-of-frame pulse |
| eofStrobe | input | 1 | End-of-frame pulse |
| bitStrobe | input | 1 | A decoded data bit is present |
| bitValue | input | 1 | Value of the decoded bit |
| collStrobe | input | 1 | The bit presented with bitStrobe is a collision |
| byteWrValid | output | 1 | One-cycle FIFO write strobe |
| byteWrData | output | 8 | Byte to write |
| lastBits | output | 3 | Fill level of the final byte, 0 = full |
| collPos | output | 7 | Absolute bit position of the first collision |
| collPosValid | output | 1 | collPos holds a collision inside the first 64 positions |

## Verification
The hardest case to reach is the edge of the 64-position collision window combined with a non-zero offset. Reaching it takes a frame of around sixty bits with a collision on exactly the right bit. The bench sends 80-bit frames at offset 5 with the collision on bit 58 or bit 59, which puts it on either side of the boundary. A full sweep covers every offset, every frame length from 0 to 20, three collision placements with a later second collision, and both zero-forcing settings. Idle cycles with stray collision strobes are mixed into each frame.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;
  localparam int BYTE_W      = 8;
  localparam int IDX_W       = $clog2(BYTE_W);
  localparam int COLL_W      = 7;
  localparam int COLL_WINDOW = 64;

  typedef struct packed {
    logic             clearFrame;
    logic             storeBit;
    logic             storeVal;
    logic [IDX_W-1:0] bitIdx;
    logic             emitByte;
    logic             flushByte;
  } packCtrl_t;
endpackage

// File: rtl/rx_pack_ctrl.sv
module rx_pack_ctrl
  import rx_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  alignCfg,
  input  logic              keepAfterColl,
  input  logic              sofStrobe,
  input  logic              eofStrobe,
  input  logic              bitStrobe,
  input  logic              bitValue,
  input  logic              collStrobe,
  output packCtrl_t         ctrl,
  output logic [IDX_W-1:0]  lastBits,
  output logic [COLL_W-1:0] collPos,
  output logic              collPosValid
);
  localparam logic [IDX_W-1:0]  IDX_MAX = IDX_W'(BYTE_W - 1);
  localparam logic [COLL_W-1:0] ABS_MAX = {COLL_W{1'b1}};
  localparam logic [COLL_W-1:0] WIN_LIM = COLL_W'(COLL_WINDOW);

  logic              inFrame;
  logic              pending;
  logic              collSeen;
  logic [IDX_W-1:0]  bitPos;
  logic [COLL_W-1:0] absPos;
  logic              bitTake;

  always_comb begin
    bitTake        = inFrame && bitStrobe && !sofStrobe && !eofStrobe;
    ctrl.clearFrame = sofStrobe;
    ctrl.storeBit   = bitTake;
    ctrl.storeVal   = bitValue && !(collSeen && !keepAfterColl);
    ctrl.bitIdx     = bitPos;
    ctrl.emitByte   = bitTake && (bitPos == IDX_MAX);
    ctrl.flushByte  = inFrame && eofStrobe && !sofStrobe && pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame      <= 1'b0;
      pending      <= 1'b0;
      collSeen     <= 1'b0;
      bitPos       <= '0;
      absPos       <= '0;
      lastBits     <= '0;
      collPos      <= '0;
      collPosValid <= 1'b0;
    end else if (sofStrobe) begin
      inFrame      <= 1'b1;
      pending      <= 1'b0;
      collSeen     <= 1'b0;
      bitPos       <= alignCfg;
      absPos       <= COLL_W'(alignCfg);
      lastBits     <= '0;
      collPos      <= '0;
      collPosValid <= 1'b0;
    end else if (inFrame && eofStrobe) begin
      inFrame  <= 1'b0;
      pending  <= 1'b0;
      lastBits <= bitPos;
    end else if (bitTake) begin
      bitPos  <= bitPos + 1'b1;
      pending <= (bitPos != IDX_MAX);
      if (absPos != ABS_MAX) absPos <= absPos + 1'b1;
      if (collStrobe && !collSeen) begin
        collSeen <= 1'b1;
        if (absPos < WIN_LIM) begin
          collPos      <= absPos;
          collPosValid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_pack_data.sv
module rx_pack_data
  import rx_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  packCtrl_t         ctrl,
  output logic              byteWrValid,
  output logic [BYTE_W-1:0] byteWrData
);
  logic [BYTE_W-1:0] accByte;
  logic [BYTE_W-1:0] nextByte;

  always_comb begin
    nextByte = accByte;
    if (ctrl.storeBit) nextByte = accByte | (BYTE_W'(ctrl.storeVal) << ctrl.bitIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accByte     <= '0;
      byteWrValid <= 1'b0;
      byteWrData  <= '0;
    end else begin
      byteWrValid <= 1'b0;
      if (ctrl.clearFrame) begin
        accByte <= '0;
      end else if (ctrl.emitByte) begin
        byteWrData  <= nextByte;
        byteWrValid <= 1'b1;
        accByte     <= '0;
      end else if (ctrl.flushByte) begin
        byteWrData  <= accByte;
        byteWrValid <= 1'b1;
        accByte     <= '0;
      end else begin
        accByte <= nextByte;
      end
    end
  end
endmodule

// File: rtl/rx_bit_packer.sv
module rx_bit_packer
  import rx_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  alignCfg,
  input  logic        keepAfterColl,
  input  logic        sofStrobe,
  input  logic        eofStrobe,
  input  logic        bitStrobe,
  input  logic        bitValue,
  input  logic        collStrobe,
  output logic        byteWrValid,
  output logic [7:0]  byteWrData,
  output logic [2:0]  lastBits,
  output logic [6:0]  collPos,
  output logic        collPosValid
);
  packCtrl_t ctrl;

  rx_pack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .alignCfg(alignCfg), .keepAfterColl(keepAfterColl),
    .sofStrobe(sofStrobe), .eofStrobe(eofStrobe), .bitStrobe(bitStrobe),
    .bitValue(bitValue), .collStrobe(collStrobe), .ctrl(ctrl),
    .lastBits(lastBits), .collPos(collPos), .collPosValid(collPosValid)
  );

  rx_pack_data u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .byteWrValid(byteWrValid), .byteWrData(byteWrData)
  );
endmodule

// File: rtl/rx_bit_packer_chk.sv
module rx_bit_packer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sofStrobe,
  input logic       eofStrobe,
  input logic       bitStrobe,
  input logic       byteWrValid,
  input logic [7:0] byteWrData,
  input logic [2:0] lastBits,
  input logic [6:0] collPos,
  input logic       collPosValid
);
  a_r8_sof_clears: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |=> (lastBits == 3'd0) && !collPosValid && (collPos == 7'd0));

  a_r7_first_coll_holds: assert property (@(posedge clk) disable iff (!rstN)
    (collPosValid && !sofStrobe) |=> collPosValid && $stable(collPos));

  a_r6_pos_in_window: assert property (@(posedge clk) disable iff (!rstN)
    collPosValid |-> (collPos < 7'd64));

  a_r3_flush_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(eofStrobe) && byteWrValid && (lastBits != 3'd0)) |->
      ((byteWrData >> lastBits) == 8'd0));

  a_r2_write_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    byteWrValid |-> ($past(bitStrobe) || $past(eofStrobe)));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (byteWrValid && $past(eofStrobe)) |=> !byteWrValid);
endmodule

bind rx_bit_packer rx_bit_packer_chk u_chk (
  .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .eofStrobe(eofStrobe),
  .bitStrobe(bitStrobe), .byteWrValid(byteWrValid), .byteWrData(byteWrData),
  .lastBits(lastBits), .collPos(collPos), .collPosValid(collPosValid)
);

// File: tb/rx_bit_packer_tb.sv
module rx_bit_packer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] alignCfg = '0;
  logic       keepAfterColl = 1'b0;
  logic       sofStrobe = 1'b0, eofStrobe = 1'b0, bitStrobe = 1'b0;
  logic       bitValue = 1'b0, collStrobe = 1'b0;
  logic       byteWrValid;
  logic [7:0] byteWrData;
  logic [2:0] lastBits;
  logic [6:0] collPos;
  logic       collPosValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] gotB [0:15];
  int gotN = 0;
  logic [7:0] expB [0:15];

  always #4 clk = ~clk;

  rx_bit_packer u_dut (
    .clk(clk), .rstN(rstN), .alignCfg(alignCfg), .keepAfterColl(keepAfterColl),
    .sofStrobe(sofStrobe), .eofStrobe(eofStrobe), .bitStrobe(bitStrobe),
    .bitValue(bitValue), .collStrobe(collStrobe), .byteWrValid(byteWrValid),
    .byteWrData(byteWrData), .lastBits(lastBits), .collPos(collPos),
    .collPosValid(collPosValid)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (byteWrValid) begin
      if (gotN < 16) gotB[gotN] <= byteWrData;
      gotN <= gotN + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic bitf(input int seed, input int i);
    int x;
    x = seed * 31 + i * 11 + i * i;
    return x[2] ^ x[4];
  endfunction

  task automatic runFrame(input int align, input int n, input int c, input int c2,
                          input int keep, input int seed);
    int nb, p, expValid, expPos;
    logic v;
    for (int k = 0; k < 16; k++) expB[k] = 8'd0;
    for (int i = 0; i < n; i++) begin
      v = bitf(seed, i);
      if (keep == 0 && c >= 0 && i > c) v = 1'b0;
      p = align + i;
      expB[p / 8][p % 8] = v;
    end
    nb = (n == 0) ? 0 : (align + n + 7) / 8;
    expValid = (c >= 0 && c < n && align + c < 64) ? 1 : 0;
    expPos = expValid ? align + c : 0;

    @(negedge clk);
    gotN = 0;
    alignCfg = 3'(align); keepAfterColl = keep[0]; sofStrobe = 1'b1;
    @(negedge clk);
    sofStrobe = 1'b0;
    alignCfg = 3'(~align);
    for (int i = 0; i < n; i++) begin
      if (i % 5 == 3) begin
        bitStrobe = 1'b0; bitValue = 1'b1; collStrobe = 1'b1; // R9 stray
        @(negedge clk);
      end
      bitStrobe = 1'b1; bitValue = bitf(seed, i);
      collStrobe = (i == c || i == c2);
      @(negedge clk);
    end
    bitStrobe = 1'b0; collStrobe = 1'b0; bitValue = 1'b0;
    check("R8 lastBits cleared in frame", int'(lastBits), 0);
    eofStrobe = 1'b1; bitStrobe = 1'b1; bitValue = 1'b1; // R9 bit at eof dropped
    @(negedge clk);
    eofStrobe = 1'b0; bitStrobe = 1'b0; bitValue = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 R3 byte count", gotN, nb);
    for (int k = 0; k < nb && k < 16; k++)
      check((k == nb - 1) ? "R3 R5 R1 last byte" : "R1 R5 full byte", int'(gotB[k]), int'(expB[k]));
    check("R4 lastBits", int'(lastBits), (align + n) % 8);
    check("R6 R7 collPosValid", int'(collPosValid), expValid);
    check("R6 R7 collPos", int'(collPos), expPos);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lbSave, cpSave, cvSave;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset byteWrValid", int'(byteWrValid), 0);
    check("R8 reset lastBits", int'(lastBits), 0);
    check("R8 reset collPosValid", int'(collPosValid), 0);

    for (int a = 0; a < 8; a++)
      for (int n = 0; n <= 20; n++)
        for (int cfg = 0; cfg < 3; cfg++)
          for (int keep = 0; keep < 2; keep++) begin
            int c;
            c = (cfg == 0) ? -1 : (cfg == 1 ? n / 2 : n - 1);
            if (n == 0) c = -1;
            runFrame(a, n, c, (c >= 0) ? c + 3 : -1, keep, a * 97 + n * 5 + cfg);
          end

    // window boundary at offset 5: positions 63 and 64
    runFrame(5, 80, 58, 70, 0, 11);
    runFrame(5, 80, 59, 62, 1, 12);
    runFrame(0, 64, 63, -1, 0, 13);
    runFrame(7, 2, 0, 1, 0, 14);

    // R9: strobes outside a frame change nothing
    runFrame(3, 9, 2, -1, 1, 15);
    lbSave = int'(lastBits); cpSave = int'(collPos); cvSave = int'(collPosValid);
    gotN = 0;
    for (int i = 0; i < 12; i++) begin
      bitStrobe = 1'b1; bitValue = 1'b1; collStrobe = 1'b1;
      @(negedge clk);
    end
    bitStrobe = 1'b0; collStrobe = 1'b0; bitValue = 1'b0;
    @(negedge clk);
    check("R9 no write outside frame", gotN, 0);
    check("R9 lastBits held", int'(lastBits), lbSave);
    check("R9 collPos held", int'(collPos), cpSave);
    check("R9 collPosValid held", int'(collPosValid), cvSave);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule